// File: doc/BRIEF.md
# RGB Panel Pixel Output Pipeline

This block drives a parallel RGB TFT panel. A pair of free-running counters walks each line through four intervals: sync, back porch, active and front porch. Frames are walked through the same four intervals, one line at a time. Inside the active window the block takes one RGB565 pixel per clock from an external first-word-fall-through FIFO. It widens the pixel to 8 bits per channel with an opaque alpha, mixes it over a background colour with a constant alpha, and applies a 2x2 ordered dither. The result drives the panel's data pins together with active-high horizontal sync, vertical sync, a data-enable strobe and a forwarded pixel clock.

If the FIFO has nothing to give inside the active window, the background colour is shown in place of the missing pixel and a sticky underrun flag is raised. Background colour and alpha are plain input ports, held steady by the surrounding logic. Blanking intervals are the safe time to change them.

Top module: `rgb_panel_pipe`

## Requirements
- R1: `fifo_rd_o` is high in exactly those cycles where the line counter and the frame counter are both inside their active intervals and `fifo_empty_i` is low. It is never high in any other cycle.
- R2: Every output (`rgb_o`, `hsync_o`, `vsync_o`, `de_o`) shows the state of counter cycle n two clock edges later. `rgb_o` is zero whenever `de_o` is low.
- R3: A pixel is widened by repeating its top bits: red {r5, r5[4:2]}, green {g6, g6[5:4]}, blue {b5, b5[4:2]}. Alpha is 0xFF. With the alpha input at 0xFF, the mixed colour equals the widened pixel.
- R4: Each mixed channel equals (a*fg + (255-a)*bg)/255, with truncating division. The background input packs red in bits 23:16, green in 15:8 and blue in 7:0. With a = 0 the background colour is output.
- R5: Each line lasts H_SYNC+H_BACK+H_ACT+H_FRONT clocks, in that order (defaults 9, 29, 320, 2). `hsync_o` is high during the first H_SYNC clocks of a line.
- R6: Each frame lasts V_SYNC+V_BACK+V_ACT+V_FRONT lines, in that order (defaults 1, 3, 240, 2). `vsync_o` is high for every clock of the first V_SYNC lines.
- R7: `de_o` is high only when both counters are in their active intervals. It is never high together with `hsync_o` or `vsync_o`.
- R8: With OUT_BITS = 6, each channel c becomes q = min(63, (c + t) >> 2) and is output as {q, 2'b00}. The threshold t depends on the parity of the active-relative column x and row y: (x even, y even) gives 0, (odd, even) gives 2, (even, odd) gives 3, (odd, odd) gives 1. With OUT_BITS = 8 the colour passes unchanged.
- R9: An active cycle with `fifo_empty_i` high pops nothing and outputs the background colour, passed through the dither. It also sets `underrun_o`, which stays high until reset.
- R10: While `rst_ni` is low, every output except `pclk_o` is low. Both counters restart at the first sync clock of the first sync line.
- R11: `pclk_o` follows the block clock, so panel data changes only on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_empty_i | input | 1 | Source FIFO holds no pixel |
| fifo_data_i | input | 16 | RGB565 pixel at the FIFO head |
| fifo_rd_o | output | 1 | Pop the FIFO head this cycle |
| alpha_i | input | 8 | Constant mixing alpha |
| bg_i | input | 24 | Background colour, R in 23:16, G in 15:8, B in 7:0 |
| rgb_o | output | 24 | Panel data, R in 23:16, G in 15:8, B in 7:0 |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| pclk_o | output | 1 | Forwarded pixel clock |
| underrun_o | output | 1 | Sticky FIFO underrun flag |

## Verification
The assertions take for granted that the FIFO head is valid whenever `fifo_empty_i` is low. They also assume that `alpha_i` and `bg_i` change only while no active pixel is in flight. The opaque-pass check depends on this, because the mixer reads alpha one stage after the pop. The stimulus changes alpha and background only at the first clock of each frame, which sits a full front-porch line after the last active pixel. It models the FIFO as a queue that always presents its head, and it starves the FIFO only by forcing the empty flag, so the data pins stay well defined.

// File: rtl/rpp_pkg.sv
package rpp_pkg;

   typedef struct packed {
      logic [7:0] a;
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } argb_t;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } rgb_t;

   localparam int unsigned NUM_CH = 3;

   // widen 5/6/5 fields to 8 bits by repeating the top bits; opaque alpha
   function automatic argb_t rpp_widen(input logic [15:0] p);
      argb_t w;
      w.a = 8'hFF;
      w.r = {p[15:11], p[15:13]};
      w.g = {p[10:5], p[10:9]};
      w.b = {p[4:0], p[4:2]};
      return w;
   endfunction

endpackage

// File: rtl/rpp_timing.sv
module rpp_timing #(
   parameter int unsigned H_SYNC  = 9,
   parameter int unsigned H_BACK  = 29,
   parameter int unsigned H_ACT   = 320,
   parameter int unsigned H_FRONT = 2,
   parameter int unsigned V_SYNC  = 1,
   parameter int unsigned V_BACK  = 3,
   parameter int unsigned V_ACT   = 240,
   parameter int unsigned V_FRONT = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic active_o,
   output logic hsync_o,
   output logic vsync_o,
   output logic x_par_o,
   output logic y_par_o
);
   localparam int unsigned HT = H_SYNC + H_BACK + H_ACT + H_FRONT;
   localparam int unsigned VT = V_SYNC + V_BACK + V_ACT + V_FRONT;
   localparam int unsigned HW = $clog2(HT);
   localparam int unsigned VW = $clog2(VT);
   localparam logic [HW-1:0] H_LAST = HW'(HT - 1);
   localparam logic [VW-1:0] V_LAST = VW'(VT - 1);
   localparam logic [HW-1:0] H_SEND = HW'(H_SYNC);
   localparam logic [VW-1:0] V_SEND = VW'(V_SYNC);
   localparam logic [HW-1:0] H_A0   = HW'(H_SYNC + H_BACK);
   localparam logic [HW-1:0] H_A1   = HW'(H_SYNC + H_BACK + H_ACT);
   localparam logic [VW-1:0] V_A0   = VW'(V_SYNC + V_BACK);
   localparam logic [VW-1:0] V_A1   = VW'(V_SYNC + V_BACK + V_ACT);

   if (H_SYNC < 1 || H_ACT < 1 || V_SYNC < 1 || V_ACT < 1) begin : g_bad_timing
      $error("rpp_timing: sync and active intervals need at least one unit");
   end

   logic [HW-1:0] h_q;
   logic [VW-1:0] v_q;
   logic [HW-1:0] h_rel;
   logic [VW-1:0] v_rel;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         h_q <= '0;
         v_q <= '0;
      end else if (h_q == H_LAST) begin
         h_q <= '0;
         v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
      end else begin
         h_q <= h_q + 1'b1;
      end
   end

   always_comb begin
      h_rel    = h_q - H_A0;
      v_rel    = v_q - V_A0;
      active_o = (h_q >= H_A0) && (h_q < H_A1) && (v_q >= V_A0) && (v_q < V_A1);
      hsync_o  = (h_q < H_SEND);
      vsync_o  = (v_q < V_SEND);
      x_par_o  = h_rel[0];
      y_par_o  = v_rel[0];
   end

   // R5: the line counter steps by one until the last clock of the line
   a_r5_line_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (h_q != H_LAST) |=> (h_q == $past(h_q) + 1'b1));

   // R6: the frame counter only moves at the end of a line
   a_r6_frame_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (h_q != H_LAST) |=> $stable(v_q));

endmodule

// File: rtl/rpp_blend.sv
module rpp_blend
   import rpp_pkg::*;
(
   input  argb_t      fg_i,
   input  rgb_t       bg_i,
   input  logic [7:0] alpha_i,
   output rgb_t       mix_o
);
   logic [7:0] fg_ch  [NUM_CH];
   logic [7:0] bg_ch  [NUM_CH];
   logic [7:0] mix_ch [NUM_CH];
   logic [7:0] alpha_inv;

   always_comb begin
      alpha_inv = 8'hFF - alpha_i;
      fg_ch[0]  = fg_i.r;
      fg_ch[1]  = fg_i.g;
      fg_ch[2]  = fg_i.b;
      bg_ch[0]  = bg_i.r;
      bg_ch[1]  = bg_i.g;
      bg_ch[2]  = bg_i.b;
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [15:0] weighted;
      logic [15:0] scaled;
      assign weighted   = 16'(alpha_i) * 16'(fg_ch[ch]) + 16'(alpha_inv) * 16'(bg_ch[ch]);
      assign scaled     = weighted / 16'd255;
      assign mix_ch[ch] = scaled[7:0];
   end

   assign mix_o = '{r: mix_ch[0], g: mix_ch[1], b: mix_ch[2]};

endmodule

// File: rtl/rpp_dither.sv
module rpp_dither
   import rpp_pkg::*;
#(
   parameter int unsigned OUT_BITS = 6
) (
   input  rgb_t c_i,
   input  logic x_par_i,
   input  logic y_par_i,
   output rgb_t c_o
);
   if (OUT_BITS != 6 && OUT_BITS != 8) begin : g_bad_bits
      $error("rpp_dither: OUT_BITS must be 6 or 8");
   end

   logic [7:0] in_ch  [NUM_CH];
   logic [7:0] out_ch [NUM_CH];

   always_comb begin
      in_ch[0] = c_i.r;
      in_ch[1] = c_i.g;
      in_ch[2] = c_i.b;
   end

   if (OUT_BITS == 8) begin : g_pass
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         assign out_ch[ch] = in_ch[ch];
      end
   end else begin : g_ordered
      logic [1:0] thr;
      always_comb begin
         unique case ({x_par_i, y_par_i})
            2'b00:   thr = 2'd0;
            2'b10:   thr = 2'd2;
            2'b01:   thr = 2'd3;
            default: thr = 2'd1;
         endcase
      end
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [8:0] biased;
         logic [5:0] level;
         assign biased     = {1'b0, in_ch[ch]} + {7'd0, thr};
         assign level      = biased[8] ? 6'h3F : biased[7:2];
         assign out_ch[ch] = {level, 2'b00};
      end
   end

   assign c_o = '{r: out_ch[0], g: out_ch[1], b: out_ch[2]};

endmodule

// File: rtl/rgb_panel_pipe.sv
module rgb_panel_pipe
   import rpp_pkg::*;
#(
   parameter int unsigned H_SYNC   = 9,
   parameter int unsigned H_BACK   = 29,
   parameter int unsigned H_ACT    = 320,
   parameter int unsigned H_FRONT  = 2,
   parameter int unsigned V_SYNC   = 1,
   parameter int unsigned V_BACK   = 3,
   parameter int unsigned V_ACT    = 240,
   parameter int unsigned V_FRONT  = 2,
   parameter int unsigned OUT_BITS = 6
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        fifo_empty_i,
   input  logic [15:0] fifo_data_i,
   output logic        fifo_rd_o,
   input  logic [7:0]  alpha_i,
   input  logic [23:0] bg_i,
   output logic [23:0] rgb_o,
   output logic        hsync_o,
   output logic        vsync_o,
   output logic        de_o,
   output logic        pclk_o,
   output logic        underrun_o
);
   // timing counters
   logic tm_act, tm_hs, tm_vs, tm_xp, tm_yp;

   rpp_timing #(
      .H_SYNC (H_SYNC), .H_BACK(H_BACK), .H_ACT(H_ACT), .H_FRONT(H_FRONT),
      .V_SYNC (V_SYNC), .V_BACK(V_BACK), .V_ACT(V_ACT), .V_FRONT(V_FRONT)
   ) u_timing (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .active_o(tm_act),
      .hsync_o (tm_hs),
      .vsync_o (tm_vs),
      .x_par_o (tm_xp),
      .y_par_o (tm_yp)
   );

   assign fifo_rd_o = tm_act && !fifo_empty_i;
   assign pclk_o    = clk_i;

   // stage A: fetched pixel widened, with position and sync
   argb_t a_pix;
   logic  a_de, a_und, a_hs, a_vs, a_xp, a_yp;
   logic  und_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_pix <= '0;
         a_de  <= 1'b0;
         a_und <= 1'b0;
         a_hs  <= 1'b0;
         a_vs  <= 1'b0;
         a_xp  <= 1'b0;
         a_yp  <= 1'b0;
         und_q <= 1'b0;
      end else begin
         if (fifo_rd_o) a_pix <= rpp_widen(fifo_data_i);
         a_de  <= tm_act;
         a_und <= tm_act && fifo_empty_i;
         a_hs  <= tm_hs;
         a_vs  <= tm_vs;
         a_xp  <= tm_xp;
         a_yp  <= tm_yp;
         und_q <= und_q || (tm_act && fifo_empty_i);
      end
   end

   assign underrun_o = und_q;

   // stage B: mix, substitute on underrun, dither
   rgb_t bg_c, mix_c, pick_c, dith_c;
   assign bg_c = bg_i;

   rpp_blend u_blend (
      .fg_i   (a_pix),
      .bg_i   (bg_c),
      .alpha_i(alpha_i),
      .mix_o  (mix_c)
   );

   assign pick_c = a_und ? bg_c : mix_c;

   rpp_dither #(.OUT_BITS(OUT_BITS)) u_dither (
      .c_i    (pick_c),
      .x_par_i(a_xp),
      .y_par_i(a_yp),
      .c_o    (dith_c)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rgb_o   <= '0;
         hsync_o <= 1'b0;
         vsync_o <= 1'b0;
         de_o    <= 1'b0;
      end else begin
         rgb_o   <= a_de ? dith_c : '0;
         hsync_o <= a_hs;
         vsync_o <= a_vs;
         de_o    <= a_de;
      end
   end

   // R1: a pop always lands in an active stage-A slot
   a_r1_pop_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_rd_o |=> a_de);

   // R2: data enable trails the counters by two edges
   a_r2_de_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      de_o == $past(tm_act, 2));

   // R3: opaque alpha leaves the widened pixel unchanged
   a_r3_opaque: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_de && !a_und && alpha_i == 8'hFF) |-> (mix_c == {a_pix.r, a_pix.g, a_pix.b}));

   // R7: data enable never overlaps a sync pulse
   a_r7_de_no_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
      de_o |-> (!hsync_o && !vsync_o));

   // R9: the underrun flag never drops without reset
   a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underrun_o |=> underrun_o);

endmodule

// File: tb/tb_rgb_panel_pipe.sv
module tb_rgb_panel_pipe;
   localparam int HS = 2, HB = 2, HA = 6, HF = 2;
   localparam int VS = 1, VB = 2, VA = 3, VF = 1;
   localparam int HT = HS + HB + HA + HF;
   localparam int VT = VS + VB + VA + VF;
   localparam int HA0 = HS + HB;
   localparam int VA0 = VS + VB;

   logic        clk = 1'b0;
   logic        rst_ni;
   logic        fifo_empty_i;
   logic [15:0] fifo_data_i;
   logic        fifo_rd_o;
   logic [7:0]  alpha_i;
   logic [23:0] bg_i;
   logic [23:0] rgb_o;
   logic        hsync_o, vsync_o, de_o, pclk_o, underrun_o;

   always #4 clk = ~clk;

   rgb_panel_pipe #(
      .H_SYNC(HS), .H_BACK(HB), .H_ACT(HA), .H_FRONT(HF),
      .V_SYNC(VS), .V_BACK(VB), .V_ACT(VA), .V_FRONT(VF),
      .OUT_BITS(6)
   ) dut (
      .clk_i(clk), .rst_ni(rst_ni), .fifo_empty_i(fifo_empty_i),
      .fifo_data_i(fifo_data_i), .fifo_rd_o(fifo_rd_o), .alpha_i(alpha_i),
      .bg_i(bg_i), .rgb_o(rgb_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
      .de_o(de_o), .pclk_o(pclk_o), .underrun_o(underrun_o)
   );

   typedef struct packed {
      logic        hs;
      logic        vs;
      logic        de;
      logic [23:0] rgb;
   } exp_t;

   exp_t        expq[$];
   logic [15:0] fq[$];
   int n_chk = 0, n_bad = 0;
   int bh = 0, bv = 0, fr = 0, gen_n = 0;
   bit started = 0, pend = 0, starve = 0, done = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] gen_pix(input int n);
      if (n == 0) return 16'hFFFF;
      if (n == 1) return 16'h0000;
      if (n == 2) return 16'hF81F;
      return 16'(n * 40503) ^ 16'h5A3C;
   endfunction

   // expected panel value from R3, R4, R8, R9
   function automatic logic [23:0] model_pix(input logic [15:0] p, input logic [7:0] a,
                                             input logic [23:0] bg, input bit und,
                                             input int x, input int y);
      int fg[3];
      int bc[3];
      int c, t, q;
      logic [23:0] r;
      fg[0] = int'({p[15:11], p[15:13]});
      fg[1] = int'({p[10:5], p[10:9]});
      fg[2] = int'({p[4:0], p[4:2]});
      bc[0] = int'(bg[23:16]);
      bc[1] = int'(bg[15:8]);
      bc[2] = int'(bg[7:0]);
      t = ((x % 2) == 0) ? (((y % 2) == 0) ? 0 : 3) : (((y % 2) == 0) ? 2 : 1);
      r = '0;
      for (int ch = 0; ch < 3; ch++) begin
         c = und ? bc[ch] : (int'(a) * fg[ch] + (255 - int'(a)) * bc[ch]) / 255;
         q = (c + t) / 4;
         if (q > 63) q = 63;
         r[23 - 8*ch -: 8] = 8'(q * 4);
      end
      return r;
   endfunction

   task automatic configure();
      case (fr)
         0: begin alpha_i = 8'hFF; bg_i = 24'h000000; starve = 0; end
         1: begin alpha_i = 8'h80; bg_i = 24'h204060; end
         2: begin alpha_i = 8'h00; bg_i = 24'hA1B2C3; end
         3: begin
            chk(underrun_o == 1'b0, "R9 flag low before starving", 32'(underrun_o), 0);
            alpha_i = 8'hC8; bg_i = 24'h10F0E0; starve = 1;
         end
         4: begin
            chk(underrun_o == 1'b1, "R9 flag set after starving", 32'(underrun_o), 1);
            alpha_i = 8'h37; bg_i = 24'hFFFFFF; starve = 0;
         end
         default: ;
      endcase
      fr++;
   endtask

   task automatic cycle_body();
      exp_t e;
      bit   act, emp;
      // monitor: compare outputs against the entry pushed two cycles ago
      if (expq.size() == 2) begin
         e = expq.pop_front();
         chk(hsync_o == e.hs, "R5 hsync", 32'(hsync_o), 32'(e.hs));
         chk(vsync_o == e.vs, "R6 vsync", 32'(vsync_o), 32'(e.vs));
         chk(de_o == e.de, "R7 R2 de", 32'(de_o), 32'(e.de));
         chk(rgb_o == e.rgb, "R2 R3 R4 R8 R9 rgb", 32'(rgb_o), 32'(e.rgb));
      end
      chk(pclk_o == 1'b0, "R11 pclk low at falling edge", 32'(pclk_o), 0);
      // model the rising edge that just happened
      if (started) begin
         if (pend) void'(fq.pop_front());
         bh++;
         if (bh == HT) begin
            bh = 0;
            bv++;
            if (bv == VT) bv = 0;
         end
      end
      started = 1;
      if (bh == 0 && bv == 0) configure();
      while (fq.size() < 8) begin
         fq.push_back(gen_pix(gen_n));
         gen_n++;
      end
      emp = starve && ((bh % 3) == 0);
      fifo_empty_i = emp;
      fifo_data_i  = fq[0];
      #1;
      act = (bh >= HA0) && (bh < HA0 + HA) && (bv >= VA0) && (bv < VA0 + VA);
      chk(fifo_rd_o == (act && !emp), "R1 pop", 32'(fifo_rd_o), 32'(act && !emp));
      e.hs  = (bh < HS);
      e.vs  = (bv < VS);
      e.de  = act;
      e.rgb = act ? model_pix(fq[0], alpha_i, bg_i, emp, bh - HA0, bv - VA0) : 24'h0;
      expq.push_back(e);
      pend = act && !emp;
   endtask

   initial begin
      rst_ni = 1'b0;
      fifo_empty_i = 1'b1;
      fifo_data_i = 16'h0;
      alpha_i = 8'hFF;
      bg_i = 24'h0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk({rgb_o, hsync_o, vsync_o, de_o, underrun_o, fifo_rd_o} == '0, "R10 reset outputs",
          32'({rgb_o, hsync_o, vsync_o, de_o, underrun_o, fifo_rd_o}), 0);
      @(posedge clk);
      #1;
      chk(pclk_o == 1'b1, "R11 pclk high after rising edge", 32'(pclk_o), 1);
      @(negedge clk);
      rst_ni = 1'b1;
      cycle_body();
      for (int k = 0; k < 6 * HT * VT; k++) begin
         @(negedge clk);
         cycle_body();
      end
      chk(underrun_o == 1'b1, "R9 flag still held", 32'(underrun_o), 1);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule